// File: doc/BRIEF.md
# Pipeline Data Hazard Detector

This block sits beside the fetch stage and decides whether the instruction about to enter the pipeline conflicts with any instruction that is still in flight. Each instruction is described by decoded fields: up to two source registers, one destination register, and whether it reads or writes the condition flags. From these fields the block builds two bitmasks for every instruction. The read set has one bit per register plus one bit for the flags. The write set uses the same layout.

The incoming instruction's sets are intersected with the sets of each valid older entry. A nonzero read-new against write-old intersection is a read-after-write conflict. A nonzero write-new against write-old intersection is a write-after-write conflict. A nonzero write-new against read-old intersection is a write-after-read conflict. The three flags are ORed across all entries, and the stall is the OR of the three. Fetch holds the incoming instruction while the stall is high. The stall drops in the same cycle that the last conflicting entry's valid bit falls.

Top module: `hzd_top`

## Requirements
- R1: raw_o is 1 when the valid incoming instruction has an enabled source register equal to the enabled destination register of any valid entry.
- R2: waw_o is 1 when the enabled destination register of the valid incoming instruction equals the enabled destination register of any valid entry.
- R3: war_o is 1 when the enabled destination register of the valid incoming instruction equals an enabled source register of any valid entry.
- R4: The condition flags are one more resource in each set. Flags read by new and written by an entry give raw_o. Flags written by new and read by an entry give war_o. Flags written by both give waw_o.
- R5: An entry whose valid bit is 0 contributes to no flag, whatever its fields hold.
- R6: When new_vld_i is 0, raw_o, waw_o, war_o and stall_o are all 0.
- R7: A register field whose enable bit is 0 contributes nothing, even if its index matches.
- R8: stall_o equals raw_o | waw_o | war_o. It is purely combinational, so it falls in the same cycle that the last conflicting entry becomes invalid.
- R9: Each flag is the OR over all entries. Different entries may raise different flags at the same time, and a single entry may raise all three.
- R10: Instructions that use disjoint registers and do not share a flag access that conflicts raise no flag. This holds across the whole register index range, from register 0 to NUM_REGS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| new_vld_i | input | 1 | Incoming instruction present |
| new_src_a_i | input | REG_W | Incoming first source index |
| new_src_a_en_i | input | 1 | First source used |
| new_src_b_i | input | REG_W | Incoming second source index |
| new_src_b_en_i | input | 1 | Second source used |
| new_dst_i | input | REG_W | Incoming destination index |
| new_dst_en_i | input | 1 | Destination used |
| new_rd_flg_i | input | 1 | Incoming reads condition flags |
| new_wr_flg_i | input | 1 | Incoming writes condition flags |
| ent_vld_i | input | NUM_ENT | Per-entry in-flight valid |
| ent_src_a_i | input | NUM_ENT x REG_W | Per-entry first source index |
| ent_src_a_en_i | input | NUM_ENT | Per-entry first source used |
| ent_src_b_i | input | NUM_ENT x REG_W | Per-entry second source index |
| ent_src_b_en_i | input | NUM_ENT | Per-entry second source used |
| ent_dst_i | input | NUM_ENT x REG_W | Per-entry destination index |
| ent_dst_en_i | input | NUM_ENT | Per-entry destination used |
| ent_rd_flg_i | input | NUM_ENT | Per-entry reads flags |
| ent_wr_flg_i | input | NUM_ENT | Per-entry writes flags |
| raw_o | output | 1 | Read-after-write conflict |
| waw_o | output | 1 | Write-after-write conflict |
| war_o | output | 1 | Write-after-read conflict |
| stall_o | output | 1 | Hold the incoming instruction |

## Verification
The block holds no state, so a wrong read set or write set shows up at the flag outputs in the same cycle that the fields are applied. There is no latency that could hide it. A fault in the decoding of one register index or of the flags bit only appears when that exact resource is shared. For this reason the stimulus covers the lowest and highest indices, the flags bit on each side, and every entry slot. A fault in valid or enable gating only appears when the fields still match, so the stimulus keeps the fields matching while the gate bit is cleared.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  parameter int unsigned NUM_REGS_DEF = 16;
  parameter int unsigned NUM_ENT_DEF  = 4;
endpackage

// File: rtl/hzd_mask_enc.sv
// Builds read set (domain) and write set (range); top bit is condition flags.
module hzd_mask_enc #(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned REG_W  = $clog2(NUM_REGS),
  localparam int unsigned MASK_W = NUM_REGS + 1
) (
  input  logic [REG_W-1:0]  src_a_i,
  input  logic              src_a_en_i,
  input  logic [REG_W-1:0]  src_b_i,
  input  logic              src_b_en_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic              dst_en_i,
  input  logic              rd_flg_i,
  input  logic              wr_flg_i,
  output logic [MASK_W-1:0] dom_o,
  output logic [MASK_W-1:0] rng_o
);
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      dom_o[i] = (src_a_en_i && src_a_i == REG_W'(i)) ||
                 (src_b_en_i && src_b_i == REG_W'(i));
      rng_o[i] = dst_en_i && dst_i == REG_W'(i);
    end
    dom_o[NUM_REGS] = rd_flg_i;
    rng_o[NUM_REGS] = wr_flg_i;
  end
endmodule

// File: rtl/hzd_entry_cmp.sv
// Intersects the incoming sets with one in-flight entry's sets.
module hzd_entry_cmp #(
  parameter int unsigned MASK_W = 17
) (
  input  logic              new_vld_i,
  input  logic [MASK_W-1:0] new_dom_i,
  input  logic [MASK_W-1:0] new_rng_i,
  input  logic              ent_vld_i,
  input  logic [MASK_W-1:0] ent_dom_i,
  input  logic [MASK_W-1:0] ent_rng_i,
  output logic              raw_o,
  output logic              waw_o,
  output logic              war_o
);
  logic act;
  assign act   = new_vld_i & ent_vld_i;
  assign raw_o = act & (|(new_dom_i & ent_rng_i));
  assign waw_o = act & (|(new_rng_i & ent_rng_i));
  assign war_o = act & (|(new_rng_i & ent_dom_i));
endmodule

// File: rtl/hzd_top.sv
module hzd_top #(
  parameter int unsigned NUM_REGS = hzd_pkg::NUM_REGS_DEF,
  parameter int unsigned NUM_ENT  = hzd_pkg::NUM_ENT_DEF,
  localparam int unsigned REG_W   = $clog2(NUM_REGS),
  localparam int unsigned MASK_W  = NUM_REGS + 1
) (
  input  logic                            new_vld_i,
  input  logic [REG_W-1:0]                new_src_a_i,
  input  logic                            new_src_a_en_i,
  input  logic [REG_W-1:0]                new_src_b_i,
  input  logic                            new_src_b_en_i,
  input  logic [REG_W-1:0]                new_dst_i,
  input  logic                            new_dst_en_i,
  input  logic                            new_rd_flg_i,
  input  logic                            new_wr_flg_i,
  input  logic [NUM_ENT-1:0]              ent_vld_i,
  input  logic [NUM_ENT-1:0][REG_W-1:0]   ent_src_a_i,
  input  logic [NUM_ENT-1:0]              ent_src_a_en_i,
  input  logic [NUM_ENT-1:0][REG_W-1:0]   ent_src_b_i,
  input  logic [NUM_ENT-1:0]              ent_src_b_en_i,
  input  logic [NUM_ENT-1:0][REG_W-1:0]   ent_dst_i,
  input  logic [NUM_ENT-1:0]              ent_dst_en_i,
  input  logic [NUM_ENT-1:0]              ent_rd_flg_i,
  input  logic [NUM_ENT-1:0]              ent_wr_flg_i,
  output logic                            raw_o,
  output logic                            waw_o,
  output logic                            war_o,
  output logic                            stall_o
);
  logic [MASK_W-1:0] new_dom, new_rng;
  logic [NUM_ENT-1:0] raw_hit, waw_hit, war_hit;

  hzd_mask_enc #(.NUM_REGS(NUM_REGS)) u_new_enc (
    .src_a_i   (new_src_a_i),
    .src_a_en_i(new_src_a_en_i),
    .src_b_i   (new_src_b_i),
    .src_b_en_i(new_src_b_en_i),
    .dst_i     (new_dst_i),
    .dst_en_i  (new_dst_en_i),
    .rd_flg_i  (new_rd_flg_i),
    .wr_flg_i  (new_wr_flg_i),
    .dom_o     (new_dom),
    .rng_o     (new_rng)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    logic [MASK_W-1:0] ent_dom, ent_rng;

    hzd_mask_enc #(.NUM_REGS(NUM_REGS)) u_enc (
      .src_a_i   (ent_src_a_i[e]),
      .src_a_en_i(ent_src_a_en_i[e]),
      .src_b_i   (ent_src_b_i[e]),
      .src_b_en_i(ent_src_b_en_i[e]),
      .dst_i     (ent_dst_i[e]),
      .dst_en_i  (ent_dst_en_i[e]),
      .rd_flg_i  (ent_rd_flg_i[e]),
      .wr_flg_i  (ent_wr_flg_i[e]),
      .dom_o     (ent_dom),
      .rng_o     (ent_rng)
    );

    hzd_entry_cmp #(.MASK_W(MASK_W)) u_cmp (
      .new_vld_i(new_vld_i),
      .new_dom_i(new_dom),
      .new_rng_i(new_rng),
      .ent_vld_i(ent_vld_i[e]),
      .ent_dom_i(ent_dom),
      .ent_rng_i(ent_rng),
      .raw_o    (raw_hit[e]),
      .waw_o    (waw_hit[e]),
      .war_o    (war_hit[e])
    );
  end

  assign raw_o   = |raw_hit;
  assign waw_o   = |waw_hit;
  assign war_o   = |war_hit;
  assign stall_o = raw_o | waw_o | war_o;
endmodule

// File: rtl/hzd_chk.sv
module hzd_chk #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned NUM_ENT  = 4,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input logic                          new_vld_i,
  input logic [REG_W-1:0]              new_src_a_i,
  input logic                          new_src_a_en_i,
  input logic [REG_W-1:0]              new_src_b_i,
  input logic                          new_src_b_en_i,
  input logic [REG_W-1:0]              new_dst_i,
  input logic                          new_dst_en_i,
  input logic                          new_rd_flg_i,
  input logic                          new_wr_flg_i,
  input logic [NUM_ENT-1:0]            ent_vld_i,
  input logic [NUM_ENT-1:0][REG_W-1:0] ent_src_a_i,
  input logic [NUM_ENT-1:0]            ent_src_a_en_i,
  input logic [NUM_ENT-1:0][REG_W-1:0] ent_src_b_i,
  input logic [NUM_ENT-1:0]            ent_src_b_en_i,
  input logic [NUM_ENT-1:0][REG_W-1:0] ent_dst_i,
  input logic [NUM_ENT-1:0]            ent_dst_en_i,
  input logic [NUM_ENT-1:0]            ent_rd_flg_i,
  input logic [NUM_ENT-1:0]            ent_wr_flg_i,
  input logic                          raw_o,
  input logic                          waw_o,
  input logic                          war_o,
  input logic                          stall_o
);
  logic raw_ref, waw_ref, war_ref;

  // Index-compare reference, independent of the mask datapath.
  always_comb begin
    raw_ref = 1'b0;
    waw_ref = 1'b0;
    war_ref = 1'b0;
    for (int e = 0; e < NUM_ENT; e++) begin
      if (new_vld_i && ent_vld_i[e]) begin
        if (ent_dst_en_i[e] &&
            ((new_src_a_en_i && new_src_a_i == ent_dst_i[e]) ||
             (new_src_b_en_i && new_src_b_i == ent_dst_i[e])))
          raw_ref = 1'b1;
        if (new_rd_flg_i && ent_wr_flg_i[e]) raw_ref = 1'b1;
        if (new_dst_en_i && ent_dst_en_i[e] && new_dst_i == ent_dst_i[e])
          waw_ref = 1'b1;
        if (new_wr_flg_i && ent_wr_flg_i[e]) waw_ref = 1'b1;
        if (new_dst_en_i &&
            ((ent_src_a_en_i[e] && ent_src_a_i[e] == new_dst_i) ||
             (ent_src_b_en_i[e] && ent_src_b_i[e] == new_dst_i)))
          war_ref = 1'b1;
        if (new_wr_flg_i && ent_rd_flg_i[e]) war_ref = 1'b1;
      end
    end
  end

  always_comb begin
    // R1
    raw_match_chk: assert (raw_o == raw_ref) else $error("raw mismatch");
    // R2
    waw_match_chk: assert (waw_o == waw_ref) else $error("waw mismatch");
    // R3
    war_match_chk: assert (war_o == war_ref) else $error("war mismatch");
    // R6
    idle_quiet_chk: assert (new_vld_i || !(raw_o || waw_o || war_o || stall_o))
      else $error("flags with no incoming instruction");
    // R8
    stall_or_chk: assert (stall_o == (raw_o || waw_o || war_o))
      else $error("stall not OR of flags");
    // R5
    no_valid_quiet_chk: assert ((|ent_vld_i) || !stall_o)
      else $error("stall with no valid entry");
  end
endmodule

bind hzd_top hzd_chk #(.NUM_REGS(NUM_REGS), .NUM_ENT(NUM_ENT)) u_chk (
  .new_vld_i     (new_vld_i),
  .new_src_a_i   (new_src_a_i),
  .new_src_a_en_i(new_src_a_en_i),
  .new_src_b_i   (new_src_b_i),
  .new_src_b_en_i(new_src_b_en_i),
  .new_dst_i     (new_dst_i),
  .new_dst_en_i  (new_dst_en_i),
  .new_rd_flg_i  (new_rd_flg_i),
  .new_wr_flg_i  (new_wr_flg_i),
  .ent_vld_i     (ent_vld_i),
  .ent_src_a_i   (ent_src_a_i),
  .ent_src_a_en_i(ent_src_a_en_i),
  .ent_src_b_i   (ent_src_b_i),
  .ent_src_b_en_i(ent_src_b_en_i),
  .ent_dst_i     (ent_dst_i),
  .ent_dst_en_i  (ent_dst_en_i),
  .ent_rd_flg_i  (ent_rd_flg_i),
  .ent_wr_flg_i  (ent_wr_flg_i),
  .raw_o         (raw_o),
  .waw_o         (waw_o),
  .war_o         (war_o),
  .stall_o       (stall_o)
);

// File: tb/hzd_top_tb.sv
module hzd_top_tb;
  localparam int unsigned NUM_REGS = 16;
  localparam int unsigned NUM_ENT  = 4;
  localparam int unsigned REG_W    = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                          new_vld, new_sae, new_sbe, new_de, new_rf, new_wf;
  logic [REG_W-1:0]              new_sa, new_sb, new_d;
  logic [NUM_ENT-1:0]            ent_vld, ent_sae, ent_sbe, ent_de, ent_rf, ent_wf;
  logic [NUM_ENT-1:0][REG_W-1:0] ent_sa, ent_sb, ent_d;
  logic raw, waw, war, stall;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  hzd_top #(.NUM_REGS(NUM_REGS), .NUM_ENT(NUM_ENT)) u_dut (
    .new_vld_i(new_vld), .new_src_a_i(new_sa), .new_src_a_en_i(new_sae),
    .new_src_b_i(new_sb), .new_src_b_en_i(new_sbe), .new_dst_i(new_d),
    .new_dst_en_i(new_de), .new_rd_flg_i(new_rf), .new_wr_flg_i(new_wf),
    .ent_vld_i(ent_vld), .ent_src_a_i(ent_sa), .ent_src_a_en_i(ent_sae),
    .ent_src_b_i(ent_sb), .ent_src_b_en_i(ent_sbe), .ent_dst_i(ent_d),
    .ent_dst_en_i(ent_de), .ent_rd_flg_i(ent_rf), .ent_wr_flg_i(ent_wf),
    .raw_o(raw), .waw_o(waw), .war_o(war), .stall_o(stall)
  );

  typedef struct packed {
    logic [1:0] slot;
    logic [3:0] e_sa; logic e_sae; logic [3:0] e_sb; logic e_sbe;
    logic [3:0] e_d;  logic e_de;  logic e_rf; logic e_wf;
    logic [3:0] n_sa; logic n_sae; logic [3:0] n_sb; logic n_sbe;
    logic [3:0] n_d;  logic n_de;  logic n_rf; logic n_wf;
    logic [2:0] exp;  // {raw,waw,war}
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R1: entry writes r1, new reads r1 via src a
    '{2'd0, 4'd0,1'b0, 4'd0,1'b0, 4'd1,1'b1, 1'b0,1'b0, 4'd1,1'b1, 4'd0,1'b0, 4'd2,1'b1, 1'b0,1'b0, 3'b100, 4'd1},
    // R1: entry in slot 2 writes r5, new reads r5 via src b
    '{2'd2, 4'd0,1'b0, 4'd0,1'b0, 4'd5,1'b1, 1'b0,1'b0, 4'd3,1'b1, 4'd5,1'b1, 4'd0,1'b0, 1'b0,1'b0, 3'b100, 4'd1},
    // R2: both write r3
    '{2'd1, 4'd0,1'b0, 4'd0,1'b0, 4'd3,1'b1, 1'b0,1'b0, 4'd0,1'b0, 4'd0,1'b0, 4'd3,1'b1, 1'b0,1'b0, 3'b010, 4'd2},
    // R3: entry reads r7 (src b), new writes r7
    '{2'd3, 4'd0,1'b0, 4'd7,1'b1, 4'd0,1'b0, 1'b0,1'b0, 4'd0,1'b0, 4'd0,1'b0, 4'd7,1'b1, 1'b0,1'b0, 3'b001, 4'd3},
    // R9: single entry reads and writes r2, new does the same: all three
    '{2'd0, 4'd2,1'b1, 4'd0,1'b0, 4'd2,1'b1, 1'b0,1'b0, 4'd2,1'b1, 4'd0,1'b0, 4'd2,1'b1, 1'b0,1'b0, 3'b111, 4'd9},
    // R4: entry writes flags, new reads flags
    '{2'd1, 4'd0,1'b0, 4'd0,1'b0, 4'd0,1'b0, 1'b0,1'b1, 4'd0,1'b0, 4'd0,1'b0, 4'd0,1'b0, 1'b1,1'b0, 3'b100, 4'd4},
    // R4: entry reads flags, new writes flags
    '{2'd2, 4'd0,1'b0, 4'd0,1'b0, 4'd0,1'b0, 1'b1,1'b0, 4'd0,1'b0, 4'd0,1'b0, 4'd0,1'b0, 1'b0,1'b1, 3'b001, 4'd4},
    // R4: both write flags
    '{2'd3, 4'd0,1'b0, 4'd0,1'b0, 4'd0,1'b0, 1'b0,1'b1, 4'd0,1'b0, 4'd0,1'b0, 4'd0,1'b0, 1'b0,1'b1, 3'b010, 4'd4},
    // R7: index matches but new src enable low
    '{2'd0, 4'd0,1'b0, 4'd0,1'b0, 4'd4,1'b1, 1'b0,1'b0, 4'd4,1'b0, 4'd4,1'b0, 4'd0,1'b0, 1'b0,1'b0, 3'b000, 4'd7},
    // R7: index matches but entry dst enable low
    '{2'd1, 4'd0,1'b0, 4'd0,1'b0, 4'd6,1'b0, 1'b0,1'b0, 4'd6,1'b1, 4'd0,1'b0, 4'd6,1'b1, 1'b0,1'b0, 3'b000, 4'd7},
    // R10: disjoint registers, both read flags only
    '{2'd2, 4'd8,1'b1, 4'd0,1'b1, 4'd9,1'b1, 1'b1,1'b0, 4'd10,1'b1, 4'd12,1'b1, 4'd11,1'b1, 1'b1,1'b0, 3'b000, 4'd10},
    // R10: boundary index r15 written, new reads r15 and writes r0 (entry reads r14)
    '{2'd3, 4'd14,1'b1, 4'd0,1'b0, 4'd15,1'b1, 1'b0,1'b0, 4'd15,1'b1, 4'd0,1'b0, 4'd0,1'b1, 1'b0,1'b0, 3'b100, 4'd10}
  };

  task automatic clear_all();
    new_vld = 1'b0; new_sa = '0; new_sae = 1'b0; new_sb = '0; new_sbe = 1'b0;
    new_d = '0; new_de = 1'b0; new_rf = 1'b0; new_wf = 1'b0;
    ent_vld = '0; ent_sa = '0; ent_sae = '0; ent_sb = '0; ent_sbe = '0;
    ent_d = '0; ent_de = '0; ent_rf = '0; ent_wf = '0;
  endtask

  task automatic check(input string tag, input logic [2:0] exp_flags);
    logic [3:0] act, expv;
    act  = {raw, waw, war, stall};
    expv = {exp_flags, |exp_flags};
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: {raw,waw,war,stall} actual=%b expected=%b", tag, act, expv);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_all();
    @(negedge clk); #1;
    check("R5 idle start", 3'b000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      clear_all();
      new_vld = 1'b1;
      new_sa = VECS[i].n_sa; new_sae = VECS[i].n_sae;
      new_sb = VECS[i].n_sb; new_sbe = VECS[i].n_sbe;
      new_d  = VECS[i].n_d;  new_de  = VECS[i].n_de;
      new_rf = VECS[i].n_rf; new_wf  = VECS[i].n_wf;
      ent_vld[VECS[i].slot] = 1'b1;
      ent_sa[VECS[i].slot]  = VECS[i].e_sa; ent_sae[VECS[i].slot] = VECS[i].e_sae;
      ent_sb[VECS[i].slot]  = VECS[i].e_sb; ent_sbe[VECS[i].slot] = VECS[i].e_sbe;
      ent_d[VECS[i].slot]   = VECS[i].e_d;  ent_de[VECS[i].slot]  = VECS[i].e_de;
      ent_rf[VECS[i].slot]  = VECS[i].e_rf; ent_wf[VECS[i].slot]  = VECS[i].e_wf;
      #1;
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
    end

    // R5: conflicting fields in an invalid entry
    @(negedge clk);
    clear_all();
    new_vld = 1'b1; new_sa = 4'd1; new_sae = 1'b1; new_d = 4'd1; new_de = 1'b1;
    ent_d[0] = 4'd1; ent_de[0] = 1'b1; ent_sa[0] = 4'd1; ent_sae[0] = 1'b1;
    #1; check("R5 invalid entry", 3'b000);
    ent_vld[0] = 1'b1;
    #1; check("R5 entry made valid", 3'b111);

    // R6: same conflict, incoming not valid
    new_vld = 1'b0;
    #1; check("R6 new not valid", 3'b000);

    // R9: raw from entry 0, war from entry 3 at once
    @(negedge clk);
    clear_all();
    new_vld = 1'b1; new_sa = 4'd2; new_sae = 1'b1; new_d = 4'd9; new_de = 1'b1;
    ent_vld[0] = 1'b1; ent_d[0] = 4'd2; ent_de[0] = 1'b1;
    ent_vld[3] = 1'b1; ent_sb[3] = 4'd9; ent_sbe[3] = 1'b1;
    #1; check("R9 two entries", 3'b101);

    // R8: retire entries; stall follows valid in the same cycle
    @(negedge clk);
    ent_vld[0] = 1'b0;
    #1; check("R8 entry 0 retired", 3'b001);
    @(negedge clk);
    ent_vld[3] = 1'b0;
    #1; check("R8 all retired", 3'b000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule